// File: doc/BRIEF.md
# BLDC Hall Commutation Decoder

This block turns the three Hall-sensor position signals of a brushless DC motor into six bridge-switch enables: three for the high-side switches and three for the low-side switches of a three-phase bridge. The Hall inputs pass through a synchroniser. They are then matched against the decode table chosen by a two-bit spacing select, which covers 60, 120, 240 and 300 electrical degrees between sensors. The match gives a six-step rotor index. A direction input selects the forward or the reverse pair for that index. A separate mode input switches the block to four-phase operation, in which only two sensors are used and one switch is on at a time.

Three overrides sit in front of the output register. Brake shorts the windings through the low side and wins over every other input. A low enable turns every switch off. An inhibit from a neighbouring PWM or overcurrent block also turns every switch off, but it has no effect while brake is high. A sensor code that is not a legal position for the chosen spacing turns every switch off. The outputs are registered, so no glitch reaches the bridge while a step changes.

Top module: `bldc_hall_commutator`

## Requirements
- R1: While `rst_ni` is low, `upper_o` and `lower_o` are both 3'b000.
- R2: With `spacing_i`=01, `quad_mode_i`=0, `dir_i`=1, `enable_i`=1, `brake_i`=0 and `inhibit_i`=0, each Hall code turns on the switch pair given below. The Hall code is written {S1,S2,S3} = `hall_i[2:0]`. Upper switches U1..U3 are `upper_o[0..2]` and lower switches L1..L3 are `lower_o[0..2]`. The mapping is 100→(U2,L1), 110→(U2,L3), 010→(U1,L3), 011→(U1,L2), 001→(U3,L2), 101→(U3,L1). At most one upper and at most one lower switch is ever on, except under brake.
- R3: With `dir_i`=0, a valid code at step k of the forward list drives the pair of step (k+3) mod 6. The forward pair list is (U2,L1),(U2,L3),(U1,L3),(U1,L2),(U3,L2),(U3,L1).
- R4: The other spacings assign codes to steps 0..5 as follows. 00 (60°): 000,100,110,111,011,001. 10 (240°): 100,101,001,011,010,110. 11 (300°): 000,001,011,111,110,100. Spacing 01 (120°) uses the order given in R2.
- R5: A code absent from the selected table turns all six outputs off. These codes are 000 and 111 for 120° and 240°, and 010 and 101 for 60° and 300°.
- R6: With `quad_mode_i`=1, `spacing_i` is ignored and {S1,S2} steps 00,10,11,01 as q=0..3. Any code with S2≠S3 is invalid and turns all outputs off. With `dir_i`=1, q=0..3 turns on L1, L3, U1, U3 in that order. With `dir_i`=0, the same q values turn on U1, U3, L1, L3. Only the one listed switch is on.
- R7: `brake_i`=1 gives `upper_o`=000 and `lower_o`=111 regardless of every other input.
- R8: With `brake_i`=0, `enable_i`=0 turns all outputs off.
- R9: With `brake_i`=0, `inhibit_i`=1 turns all outputs off. With `brake_i`=1, inhibit has no effect.
- R10: A change on `hall_i` reaches the outputs on the third rising clock edge after it is applied. A change on any control input reaches the outputs on the first rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hall_i | input | 3 | Hall sensors {S1,S2,S3}, asynchronous |
| spacing_i | input | 2 | Sensor spacing: 00=60°, 01=120°, 10=240°, 11=300° |
| quad_mode_i | input | 1 | 1 selects four-phase operation |
| dir_i | input | 1 | 1 forward, 0 reverse |
| brake_i | input | 1 | Brake: all low-side switches on, highest priority |
| enable_i | input | 1 | 0 turns all switches off |
| inhibit_i | input | 1 | Drive inhibit from PWM/overcurrent logic |
| upper_o | output | 3 | High-side switch enables U1..U3 |
| lower_o | output | 3 | Low-side switch enables L1..L3 |

## Verification
Directed walks run every spacing table in both directions and the four-phase cycle in both directions. A wrong step index shows as a wrong pair, and a wrong offset shows only in reverse. Every illegal code is applied for each spacing, which separates the invalid sets of the 60/300 tables from those of the 120/240 tables. Random vectors mix brake, enable and inhibit with every code and mode, so the priority order among the overrides is tested in all combinations. Timed steps confirm the three-edge Hall latency and the one-edge control latency.

// File: rtl/bldc_comm_pkg.sv
package bldc_comm_pkg;

  localparam int HALL_W  = 3;
  localparam int LEG_N   = 3;
  localparam int STEPS   = 6;
  localparam int QSTEPS  = 4;
  localparam int STEP_W  = $clog2(STEPS);

  typedef logic [HALL_W-1:0] hall_t;
  typedef logic [STEP_W-1:0] step_t;

  typedef enum logic [1:0] {
    SP_60  = 2'b00,
    SP_120 = 2'b01,
    SP_240 = 2'b10,
    SP_300 = 2'b11
  } spacing_e;

  typedef struct packed {
    logic [LEG_N-1:0] hi;
    logic [LEG_N-1:0] lo;
  } drive_t;

  // Sensor code expected at six-step index k for each spacing
  function automatic hall_t step_code(spacing_e sp, step_t k);
    hall_t c;
    c = '0;
    unique case (sp)
      SP_60: case (k)
        3'd0: c = 3'b000; 3'd1: c = 3'b100; 3'd2: c = 3'b110;
        3'd3: c = 3'b111; 3'd4: c = 3'b011; default: c = 3'b001;
      endcase
      SP_120: case (k)
        3'd0: c = 3'b100; 3'd1: c = 3'b110; 3'd2: c = 3'b010;
        3'd3: c = 3'b011; 3'd4: c = 3'b001; default: c = 3'b101;
      endcase
      SP_240: case (k)
        3'd0: c = 3'b100; 3'd1: c = 3'b101; 3'd2: c = 3'b001;
        3'd3: c = 3'b011; 3'd4: c = 3'b010; default: c = 3'b110;
      endcase
      default: case (k)
        3'd0: c = 3'b000; 3'd1: c = 3'b001; 3'd2: c = 3'b011;
        3'd3: c = 3'b111; 3'd4: c = 3'b110; default: c = 3'b100;
      endcase
    endcase
    return c;
  endfunction

endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d_i;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/step_decoder.sv
module step_decoder
  import bldc_comm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  spacing_e spacing_i,
  input  logic     quad_i,
  input  hall_t    hall_i,
  output logic     valid_o,
  output step_t    step_o
);

  always_comb begin
    valid_o = 1'b0;
    step_o  = '0;
    if (quad_i) begin
      valid_o = (hall_i[1] == hall_i[0]);
      unique case (hall_i[2:1])
        2'b00:   step_o = 3'd0;
        2'b10:   step_o = 3'd1;
        2'b11:   step_o = 3'd2;
        default: step_o = 3'd3;
      endcase
    end else begin
      for (int k = 0; k < STEPS; k++) begin
        if (step_code(spacing_i, step_t'(k)) == hall_i) begin
          valid_o = 1'b1;
          step_o  = step_t'(k);
        end
      end
    end
  end

  // R5: the all-equal codes never decode at 120 degrees
  assert_invalid_120_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!quad_i && spacing_i == SP_120 && (hall_i == 3'b000 || hall_i == 3'b111)) |-> !valid_o);

  // R6: four-phase index stays inside its four steps
  assert_quad_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quad_i |-> (step_o < step_t'(QSTEPS)));

endmodule

// File: rtl/drive_encoder.sv
module drive_encoder
  import bldc_comm_pkg::*;
(
  input  logic   quad_i,
  input  logic   dir_i,
  input  logic   valid_i,
  input  step_t  step_i,
  input  logic   brake_i,
  input  logic   enable_i,
  input  logic   inhibit_i,
  output drive_t drive_o
);

  step_t k6;
  logic [1:0] q4;

  always_comb begin
    k6 = dir_i ? step_i : ((step_i >= 3'd3) ? step_i - 3'd3 : step_i + 3'd3);
    q4 = dir_i ? step_i[1:0] : step_i[1:0] + 2'd2;
  end

  always_comb begin
    drive_o = '0;
    if (brake_i) begin
      drive_o.lo = '1;
    end else if (enable_i && !inhibit_i && valid_i) begin
      if (quad_i) begin
        unique case (q4)
          2'd0:    drive_o.lo = 3'b001;
          2'd1:    drive_o.lo = 3'b100;
          2'd2:    drive_o.hi = 3'b001;
          default: drive_o.hi = 3'b100;
        endcase
      end else begin
        unique case (k6)
          3'd0:    begin drive_o.hi = 3'b010; drive_o.lo = 3'b001; end
          3'd1:    begin drive_o.hi = 3'b010; drive_o.lo = 3'b100; end
          3'd2:    begin drive_o.hi = 3'b001; drive_o.lo = 3'b100; end
          3'd3:    begin drive_o.hi = 3'b001; drive_o.lo = 3'b010; end
          3'd4:    begin drive_o.hi = 3'b100; drive_o.lo = 3'b010; end
          default: begin drive_o.hi = 3'b100; drive_o.lo = 3'b001; end
        endcase
      end
    end
  end

endmodule

// File: rtl/bldc_hall_commutator.sv
module bldc_hall_commutator
  import bldc_comm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [HALL_W-1:0] hall_i,
  input  logic [1:0]       spacing_i,
  input  logic             quad_mode_i,
  input  logic             dir_i,
  input  logic             brake_i,
  input  logic             enable_i,
  input  logic             inhibit_i,
  output logic [LEG_N-1:0] upper_o,
  output logic [LEG_N-1:0] lower_o
);

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[RST_STAGES-1];

  hall_t  hall_s;
  logic   code_valid;
  step_t  step_idx;
  drive_t drive_d, drive_q;
  logic   drive_load;

  hall_sync #(.WIDTH(HALL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .d_i    (hall_i),
    .q_o    (hall_s)
  );

  step_decoder u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .spacing_i (spacing_e'(spacing_i)),
    .quad_i    (quad_mode_i),
    .hall_i    (hall_s),
    .valid_o   (code_valid),
    .step_o    (step_idx)
  );

  drive_encoder u_enc (
    .quad_i    (quad_mode_i),
    .dir_i     (dir_i),
    .valid_i   (code_valid),
    .step_i    (step_idx),
    .brake_i   (brake_i),
    .enable_i  (enable_i),
    .inhibit_i (inhibit_i),
    .drive_o   (drive_d)
  );

  assign drive_load = (drive_d != drive_q);

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)     drive_q <= '0;
    else if (drive_load) drive_q <= drive_d;
  end

  assign upper_o = drive_q.hi;
  assign lower_o = drive_q.lo;

  // R1: outputs off while reset is held
  assert_reset_off_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (upper_o == '0 && lower_o == '0));

  // R2: one switch per side at most, outside braking
  assert_single_pair_R2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (lower_o != '1) |-> ($onehot0(upper_o) && $onehot0(lower_o)));

  // R7: brake forces low side on next edge
  assert_brake_priority_R7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    brake_i |=> (upper_o == '0 && lower_o == '1));

  // R8: enable low turns all switches off
  assert_enable_off_R8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!brake_i && !enable_i) |=> (upper_o == '0 && lower_o == '0));

  // R9: inhibit turns all switches off unless braking
  assert_inhibit_off_R9: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!brake_i && inhibit_i) |=> (upper_o == '0 && lower_o == '0));

  // R5: an illegal sensor code yields all off
  assert_invalid_off_R5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!brake_i && !code_valid) |=> (upper_o == '0 && lower_o == '0));

endmodule

// File: tb/bldc_hall_commutator_tb.sv
module bldc_hall_commutator_tb;

  localparam time CLK_P = 4ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] hall;
  logic [1:0] spacing;
  logic       quad, dir, brake, en, inh;
  logic [2:0] upper, lower;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bldc_hall_commutator u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hall_i(hall), .spacing_i(spacing),
    .quad_mode_i(quad), .dir_i(dir), .brake_i(brake), .enable_i(en),
    .inhibit_i(inh), .upper_o(upper), .lower_o(lower)
  );

  // Code order per spacing, step 0 first (R2, R4)
  function automatic logic [2:0] seq_code(logic [1:0] sp, int k);
    logic [2:0] t60[6]  = '{3'b000, 3'b100, 3'b110, 3'b111, 3'b011, 3'b001};
    logic [2:0] t120[6] = '{3'b100, 3'b110, 3'b010, 3'b011, 3'b001, 3'b101};
    logic [2:0] t240[6] = '{3'b100, 3'b101, 3'b001, 3'b011, 3'b010, 3'b110};
    logic [2:0] t300[6] = '{3'b000, 3'b001, 3'b011, 3'b111, 3'b110, 3'b100};
    case (sp)
      2'b00: return t60[k];
      2'b01: return t120[k];
      2'b10: return t240[k];
      default: return t300[k];
    endcase
  endfunction

  function automatic logic [5:0] expect_drive(logic [1:0] sp, logic qm, logic d,
      logic br, logic e, logic ih, logic [2:0] h);
    int hi_n[6] = '{2, 2, 1, 1, 3, 3};
    int lo_n[6] = '{1, 3, 3, 2, 2, 1};
    int k, q;
    logic [2:0] hv, lv;
    if (br) return {3'b000, 3'b111};
    if (!e || ih) return 6'b0;
    hv = 3'b000; lv = 3'b000;
    if (qm) begin
      if (h[1] != h[0]) return 6'b0;
      case (h[2:1]) 2'b00: q = 0; 2'b10: q = 1; 2'b11: q = 2; default: q = 3; endcase
      if (!d) q = (q + 2) % 4;
      case (q)
        0: lv = 3'b001; 1: lv = 3'b100; 2: hv = 3'b001; default: hv = 3'b100;
      endcase
      return {hv, lv};
    end
    k = -1;
    for (int i = 0; i < 6; i++) if (seq_code(sp, i) == h) k = i;
    if (k < 0) return 6'b0;
    if (!d) k = (k + 3) % 6;
    hv[hi_n[k]-1] = 1'b1;
    lv[lo_n[k]-1] = 1'b1;
    return {hv, lv};
  endfunction

  function automatic string tag_for();
    if (brake) return "R7";
    if (!en) return "R8";
    if (inh) return "R9";
    if (quad) return "R6";
    if (expect_drive(spacing, quad, dir, 1'b0, 1'b1, 1'b0, hall) == 6'b0) return "R5";
    if (!dir) return "R3";
    if (spacing == 2'b01) return "R2";
    return "R4";
  endfunction

  task automatic check(string tag, logic [5:0] exp);
    n_chk++;
    if ({upper, lower} !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b_%b expected %b_%b (sp=%b q=%b dir=%b br=%b en=%b inh=%b hall=%b)",
               tag, upper, lower, exp[5:3], exp[2:0], spacing, quad, dir, brake, en, inh, hall);
    end
  endtask

  // Apply at falling edge, sample after the third rising edge
  task automatic apply(logic [1:0] sp, logic qm, logic d, logic br, logic e,
                       logic ih, logic [2:0] h);
    @(negedge clk);
    spacing = sp; quad = qm; dir = d; brake = br; en = e; inh = ih; hall = h;
    repeat (3) @(posedge clk);
    #1;
    check(tag_for(), expect_drive(sp, qm, d, br, e, ih, h));
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0] old_v, new_v;
    void'($urandom(32'd1234));
    rst_n = 1'b0; hall = 3'b100; spacing = 2'b01; quad = 1'b0;
    dir = 1'b1; brake = 1'b0; en = 1'b1; inh = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", 6'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // Full table walks, both directions, every spacing (R2 R3 R4 R5)
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 2; d++)
        for (int h = 0; h < 8; h++)
          apply(2'(s), 1'b0, 1'(d), 1'b0, 1'b1, 1'b0, 3'(h));

    // Four-phase, both directions, including S2 != S3 (R6)
    for (int d = 0; d < 2; d++)
      for (int h = 0; h < 8; h++)
        apply(2'(h % 4), 1'b1, 1'(d), 1'b0, 1'b1, 1'b0, 3'(h));

    // Override corner cases (R7 R8 R9)
    apply(2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'b000);
    apply(2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 3'b100);
    apply(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b100);
    apply(2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3'b100);
    apply(2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'b011);

    // Hall latency: old value after two edges, new after three (R10)
    apply(2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b100);
    old_v = expect_drive(2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b100);
    new_v = expect_drive(2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b110);
    @(negedge clk);
    hall = 3'b110;
    repeat (2) @(posedge clk);
    #1;
    check("R10", old_v);
    @(posedge clk);
    #1;
    check("R10", new_v);
    // Control latency: one edge
    @(negedge clk);
    en = 1'b0;
    @(posedge clk);
    #1;
    check("R10", 6'b0);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [2:0] h;
      logic qm;
      h  = 3'($urandom_range(0, 7));
      qm = ($urandom_range(0, 3) == 0);
      if (qm && $urandom_range(0, 3) != 0) h[0] = h[1];
      apply(2'($urandom_range(0, 3)), qm, 1'($urandom_range(0, 1)),
            ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) != 0),
            ($urandom_range(0, 7) == 0), h);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule